// File: doc/BRIEF.md
# Selectable ADC Output Code Formatter

This block sits after a 12-bit converter core. It takes each sample in offset-binary form and registers it out in one of three codes: two's complement, Gray or plain offset binary. All three codes come from the same offset-binary word. Two's complement inverts the top bit only. Gray is built from the offset-binary bits, not from the two's-complement word.

A 2-bit format field picks the code. The field lives in a configuration register that is loaded through a small write port (write enable, address, data). The register responds to one fixed address and ignores writes to any other address.

A separate combinational decoder turns a Gray word back into offset binary, working from the top bit down. Downstream logic or a bench can use it to confirm round trips.

Top module: `adc_code_fmt`

## Requirements
- R1: A synchronous active-high reset clears `out_vld` in the following cycle and returns the format field to two's complement. A sample sent after reset with no write comes out in two's complement.
- R2: With format code 2'b10 (offset binary), `out_word` equals the input sample unchanged.
- R3: With format code 2'b00 (two's complement), `out_word` equals the sample with bit 11 inverted and bits 10..0 unchanged. Code 2'b11 behaves the same as 2'b00.
- R4: With format code 2'b01 (Gray), `out_word[11]` equals sample bit 11. Each lower bit i equals sample bit i XOR sample bit i+1.
- R5: Fixed code points hold for each input:
  - 0x000 gives 0x800 in two's complement and 0x000 in Gray.
  - 0x800 gives 0x000 in two's complement and 0xC00 in Gray.
  - 0xFFE gives 0x7FE in two's complement and 0x801 in Gray.
  - 0xFFF gives 0x7FF in two's complement and 0x800 in Gray.
- R6: The format field is loaded from `cfg_wdata[1:0]` only when `cfg_we` is high and `cfg_addr` equals 0x73. A write to any other address leaves the format unchanged. `cfg_wdata[7:2]` are ignored.
- R7: `out_vld` is `smp_vld` delayed by exactly one clock, and `out_word` is updated in that same cycle. When no sample is accepted, `out_word` keeps its previous value.
- R8: A sample presented in the same cycle as a format write is coded with the old format. Every sample in later cycles is coded with the new format.
- R9: `dec_bin` is a combinational function of `dec_gray`. Bit 11 is copied, and each lower bit i equals `dec_gray[i]` XOR `dec_bin[i+1]`. Decoding the Gray code of any word gives back that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data, format in bits 1:0 |
| smp_vld | input | 1 | Input sample valid |
| smp_ob | input | 12 | Input sample, offset binary |
| out_vld | output | 1 | Output word valid, one clock after input |
| out_word | output | 12 | Formatted output word |
| dec_gray | input | 12 | Gray word to decode |
| dec_bin | output | 12 | Decoded offset-binary word |

## Verification
A wrong stored format shows up on `out_word` in the cycle after the next valid sample. Depending on the stored value, that word has a wrong top bit or wrong lower Gray bits. A write accepted from a wrong address, or a field taken from the wrong data bits, shows up the same way on the first sample after that write.

A wrong valid flag is visible one cycle after the sample. A word that is not held shows up in any cycle without a sample. Decoder faults are combinational and appear as soon as `dec_gray` changes.

// File: rtl/adc_code_fmt_pkg.sv
package adc_code_fmt_pkg;
    localparam int SMP_W = 12;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'b00,
        FMT_GRAY = 2'b01,
        FMT_OFFS = 2'b10,
        FMT_ALT  = 2'b11
    } fmt_e;

    localparam fmt_e FMT_RESET = FMT_TWOS;
endpackage

// File: rtl/fmt_cfg_reg.sv
module fmt_cfg_reg
    import adc_code_fmt_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] REG_ADDR = 8'h73
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output fmt_e          fmt
);
    localparam int FW = $bits(fmt_e);

    fmt_e fmt_d, fmt_q;

    always_comb begin
        fmt_d = fmt_q;
        if (we && (addr == REG_ADDR)) begin
            fmt_d = fmt_e'(wdata[FW-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= FMT_RESET;
        end else begin
            fmt_q <= fmt_d;
        end
    end

    assign fmt = fmt_q;
endmodule

// File: rtl/fmt_encode.sv
module fmt_encode
    import adc_code_fmt_pkg::*;
#(
    parameter int W = SMP_W
) (
    input  logic [W-1:0] ob,
    input  fmt_e         fmt,
    output logic [W-1:0] word
);
    logic [W-1:0] gray;
    logic [W-1:0] twos;

    assign gray[W-1] = ob[W-1];
    generate
        for (genvar i = 0; i < W-1; i++) begin : g_gray
            assign gray[i] = ob[i] ^ ob[i+1];
        end
    endgenerate

    assign twos = {~ob[W-1], ob[W-2:0]};

    always_comb begin
        unique case (fmt)
            FMT_GRAY: word = gray;
            FMT_OFFS: word = ob;
            default:  word = twos;
        endcase
    end
endmodule

// File: rtl/gray_decode.sv
module gray_decode #(
    parameter int W = 12
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    assign bin[W-1] = gray[W-1];
    generate
        for (genvar i = W-2; i >= 0; i--) begin : g_bit
            assign bin[i] = gray[i] ^ bin[i+1];
        end
    endgenerate
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
    import adc_code_fmt_pkg::*;
#(
    parameter int            W        = SMP_W,
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] CFG_ADDR = 8'h73
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          smp_vld,
    input  logic [W-1:0]  smp_ob,
    output logic          out_vld,
    output logic [W-1:0]  out_word,
    input  logic [W-1:0]  dec_gray,
    output logic [W-1:0]  dec_bin
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } pipe_t;

    fmt_e         cur_fmt;
    logic [W-1:0] enc_word;
    pipe_t        pipe_d, pipe_q;

    fmt_cfg_reg #(
        .AW       (AW),
        .DW       (DW),
        .REG_ADDR (CFG_ADDR)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .fmt   (cur_fmt)
    );

    fmt_encode #(.W(W)) u_enc (
        .ob   (smp_ob),
        .fmt  (cur_fmt),
        .word (enc_word)
    );

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = smp_vld;
        if (smp_vld) begin
            pipe_d.word = enc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_vld  = pipe_q.vld;
    assign out_word = pipe_q.word;

    gray_decode #(.W(W)) u_dec (
        .gray (dec_gray),
        .bin  (dec_bin)
    );
endmodule

// File: rtl/adc_code_fmt_chk.sv
module adc_code_fmt_chk
    import adc_code_fmt_pkg::*;
#(
    parameter int            W        = SMP_W,
    parameter int            AW       = 8,
    parameter logic [AW-1:0] CFG_ADDR = 8'h73
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_addr,
    input logic          smp_vld,
    input logic [W-1:0]  smp_ob,
    input logic          out_vld,
    input logic [W-1:0]  out_word,
    input fmt_e          cur_fmt
);
    a_r1_reset_clears_vld: assert property (@(posedge clk)
        rst |=> !out_vld);

    a_r7_vld_follows: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> out_vld);

    a_r7_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !out_vld);

    a_r7_word_held: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(out_word));

    a_r2_offs_pass: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cur_fmt == FMT_OFFS) |=> out_word == $past(smp_ob));

    a_r3_twos_msb: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (cur_fmt == FMT_TWOS || cur_fmt == FMT_ALT))
        |=> (out_word[W-1] != $past(smp_ob[W-1]))
            && (out_word[W-2:0] == $past(smp_ob[W-2:0])));

    a_r4_gray_top: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cur_fmt == FMT_GRAY) |=> out_word[W-1] == $past(smp_ob[W-1]));

    a_r6_other_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we || cfg_addr != CFG_ADDR) |=> $stable(cur_fmt));
endmodule

bind adc_code_fmt adc_code_fmt_chk #(
    .W        (W),
    .AW       (AW),
    .CFG_ADDR (CFG_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .smp_vld  (smp_vld),
    .smp_ob   (smp_ob),
    .out_vld  (out_vld),
    .out_word (out_word),
    .cur_fmt  (cur_fmt)
);

// File: tb/adc_code_fmt_tb.sv
module adc_code_fmt_tb;
    localparam int W = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        smp_vld = 1'b0;
    logic [W-1:0] smp_ob = '0;
    logic        out_vld;
    logic [W-1:0] out_word;
    logic [W-1:0] dec_gray = '0;
    logic [W-1:0] dec_bin;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] m_fmt = 2'b00;
    logic [W-1:0] m_word = '0;

    always #2 clk = ~clk;

    adc_code_fmt u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .smp_ob(smp_ob),
        .out_vld(out_vld), .out_word(out_word),
        .dec_gray(dec_gray), .dec_bin(dec_bin)
    );

    function automatic logic [W-1:0] ref_gray(input logic [W-1:0] v);
        return v ^ (v >> 1);
    endfunction

    function automatic logic [W-1:0] ref_fmt(input logic [W-1:0] v, input logic [1:0] f);
        case (f)
            2'b01:   return ref_gray(v);
            2'b10:   return v;
            default: return v ^ (1 << (W-1));
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, check after the edge
    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic v, input logic [W-1:0] ob, input string req);
        logic [W-1:0] exp_w;
        cfg_we = we; cfg_addr = a; cfg_wdata = d; smp_vld = v; smp_ob = ob;
        exp_w = v ? ref_fmt(ob, m_fmt) : m_word;
        @(posedge clk); #1;
        if (we && a == 8'h73) m_fmt = d[1:0];
        m_word = exp_w;
        check(req, {11'b0, out_vld}, {11'b0, v});
        check(req, out_word, exp_w);
        @(negedge clk);
        cfg_we = 1'b0; smp_vld = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", {11'b0, out_vld}, 12'h000);
        @(negedge clk);
        // R1: default two's complement after reset
        step(0, 0, 0, 1, 12'h800, "R1");
        // R5 corners in two's complement and Gray
        step(0, 0, 0, 1, 12'h000, "R5");
        step(0, 0, 0, 1, 12'hFFE, "R5");
        step(0, 0, 0, 1, 12'hFFF, "R5");
        check("R5", out_word, 12'h7FF);
        step(1, 8'h73, 8'h01, 0, 12'h0, "R6");
        step(0, 0, 0, 1, 12'h800, "R5");
        check("R5", out_word, 12'hC00);
        step(0, 0, 0, 1, 12'hFFE, "R5");
        check("R5", out_word, 12'h801);
        step(0, 0, 0, 1, 12'hFFF, "R5");
        check("R5", out_word, 12'h800);
        // R7: hold with no valid
        step(0, 0, 0, 0, 12'h123, "R7");
        // R6: wrong address ignored, upper data bits ignored
        step(1, 8'h72, 8'h02, 0, 12'h0, "R6");
        step(0, 0, 0, 1, 12'h5A5, "R6");
        step(1, 8'h73, 8'hFE, 0, 12'h0, "R6");
        step(0, 0, 0, 1, 12'h5A5, "R2");
        // R8: same-cycle write uses old format, next uses new
        step(1, 8'h73, 8'h03, 1, 12'h3C3, "R8");
        step(0, 0, 0, 1, 12'h3C3, "R3");
        // R1: reset mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1", {11'b0, out_vld}, 12'h000);
        @(negedge clk);
        rst = 1'b0; m_fmt = 2'b00;
        step(0, 0, 0, 1, 12'h001, "R1");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] r;
            logic [7:0] a;
            r = W'($urandom);
            a = ($urandom % 4 == 0) ? 8'h73 : 8'($urandom);
            step(($urandom % 3) == 0, a, 8'($urandom), ($urandom % 4) != 0, r, "R7");
            dec_gray = ref_gray(r);
            #1;
            check("R9", dec_bin, r);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule